// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block sits behind a two-wire serial memory slave and turns a stream of received data bytes into one programming operation. The slave hands it a start event, a word address, one strobe per data byte and finally a stop event. Bytes land in a 16-entry page buffer, each with its own valid bit. The column pointer advances after every byte but never leaves the page that the word address selected.

A stop that follows at least one buffered byte copies the valid slots into a 128-byte register array in one clock edge. The block then raises a busy flag for a fixed number of system clocks, which models the self-timed programming period. While busy, every bus-side input is ignored, so the slave can use the flag to withhold its acknowledge. A write-protect level, taken at the stop, suppresses the array update but not the busy period. The array is read through an asynchronous read port.

Top module: `pbw_page_writer`

## Requirements
- R1: After reset, busy_o is low and every array location reads 0x00.
- R2: The word address sets the page (address bits 6:4) and the column (bits 3:0). Each data byte is stored at the current column, and then only the column increments, modulo 16. A single data byte followed by a stop is a one-byte write.
- R3: When more than 16 bytes arrive before the stop, the column wraps within the page and a later byte replaces the earlier byte in the same slot.
- R4: A commit writes only the slots whose valid bit is set. All other locations in the page keep their previous contents.
- R5: The array does not change before the stop. After the clock edge that samples stop_i, the read port shows the new data.
- R6: A stop that commits data raises busy_o from the next cycle. busy_o then stays high for exactly WRITE_CYCLES cycles.
- R7: If wp_i is high in the cycle that stop_i is sampled, no array location changes, and busy_o still runs for the full WRITE_CYCLES.
- R8: With wp_i low, every address can be written, including the last address 0x7F.
- R9: A start event clears the buffered bytes. A stop with no buffered bytes starts no busy period and writes nothing.
- R10: While busy_o is high, start_i, addr_load_i, byte_valid_i and stop_i have no effect. They neither restart the timer nor leave bytes in the buffer.
- R11: A data byte strobed in the same cycle as stop_i is part of the commit.
- R12: rd_data_o follows rd_addr_i combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or repeated-start event, one-cycle pulse |
| addr_load_i | input | 1 | Loads the word address pointer |
| addr_i | input | 7 | Word address |
| byte_valid_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | Stop event, one-cycle pulse |
| wp_i | input | 1 | Write-protect level |
| rd_addr_i | input | 7 | Array read address |
| rd_data_o | output | 8 | Array read data |
| busy_o | output | 1 | Self-timed write cycle in progress |

## Verification
Two functions can fall in the same clock edge: the last byte strobe and the stop that commits it. The bench pulses byte_valid_i and stop_i together and expects that byte at the next column in the array once the edge has passed (R11). A second overlap is a new transaction that arrives while busy. The bench drives start, address, byte and stop inside the busy window. It then checks that the busy count stays at WRITE_CYCLES, that a later lone stop starts no cycle, and that the target address is unchanged.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned ADDR_W     = 7;
  localparam int unsigned COL_W      = 4;
  localparam int unsigned PAGE_W     = ADDR_W - COL_W;
  localparam int unsigned PAGE_BYTES = 1 << COL_W;
  localparam int unsigned DEPTH      = 1 << ADDR_W;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [COL_W-1:0]  col_t;
  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [PAGE_BYTES-1:0][DATA_W-1:0] page_data_t;
  typedef logic [PAGE_BYTES-1:0] page_mask_t;
endpackage

// File: rtl/pbw_page_buf.sv
module pbw_page_buf
  import pbw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  logic       start_i,
  input  logic       addr_load_i,
  input  addr_t      addr_i,
  input  logic       byte_valid_i,
  input  byte_t      byte_i,
  input  logic       flush_i,
  output page_t      page_nx_o,
  output page_data_t data_nx_o,
  output page_mask_t valid_nx_o
);
  page_t      page_q, page_nx;
  col_t       col_q, col_nx;
  page_data_t data_q, data_nx;
  page_mask_t valid_q, valid_nx;

  // next view includes a byte arriving together with the stop
  always_comb begin
    page_nx  = page_q;
    col_nx   = col_q;
    data_nx  = data_q;
    valid_nx = valid_q;
    if (accept_i) begin
      if (start_i) begin
        valid_nx = '0;
      end else begin
        if (addr_load_i) begin
          page_nx = addr_i[ADDR_W-1:COL_W];
          col_nx  = addr_i[COL_W-1:0];
        end
        if (byte_valid_i) begin
          data_nx[col_nx]  = byte_i;
          valid_nx[col_nx] = 1'b1;
          col_nx           = col_nx + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q  <= '0;
      col_q   <= '0;
      data_q  <= '0;
      valid_q <= '0;
    end else begin
      page_q  <= page_nx;
      col_q   <= col_nx;
      data_q  <= data_nx;
      valid_q <= flush_i ? '0 : valid_nx;
    end
  end

  assign page_nx_o  = page_nx;
  assign data_nx_o  = data_nx;
  assign valid_nx_o = valid_nx;
endmodule

// File: rtl/pbw_timer.sv
module pbw_timer #(
  parameter int unsigned CYCLES = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (go_i)         cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/pbw_array.sv
module pbw_array
  import pbw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       commit_i,
  input  logic       wp_i,
  input  page_t      page_i,
  input  page_data_t data_i,
  input  page_mask_t valid_i,
  input  addr_t      rd_addr_i,
  output byte_t      rd_data_o
);
  logic [DEPTH-1:0]             wr_en;
  logic [DEPTH-1:0][DATA_W-1:0] wr_data;
  logic [DEPTH-1:0][DATA_W-1:0] mem_q;

  for (genvar a = 0; a < DEPTH; a++) begin : g_loc
    localparam int unsigned COL  = a % PAGE_BYTES;
    localparam int unsigned PAGE = a / PAGE_BYTES;
    assign wr_en[a]   = commit_i & ~wp_i & (page_i == PAGE_W'(PAGE)) & valid_i[COL];
    assign wr_data[a] = data_i[COL];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else begin
      for (int a = 0; a < DEPTH; a++) begin
        if (wr_en[a]) mem_q[a] <= wr_data[a];
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/pbw_page_writer.sv
module pbw_page_writer
  import pbw_pkg::*;
#(
  parameter int unsigned WRITE_CYCLES = 500000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                addr_load_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                byte_valid_i,
  input  logic [DATA_W-1:0]   byte_i,
  input  logic                stop_i,
  input  logic                wp_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic                busy_o
);
  logic       accept, flush, commit;
  page_t      page_nx;
  page_data_t data_nx;
  page_mask_t valid_nx;

  assign accept = ~busy_o;
  assign flush  = accept & stop_i;
  assign commit = flush & (|valid_nx);

  pbw_page_buf i_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .start_i     (start_i),
    .addr_load_i (addr_load_i),
    .addr_i      (addr_i),
    .byte_valid_i(byte_valid_i),
    .byte_i      (byte_i),
    .flush_i     (flush),
    .page_nx_o   (page_nx),
    .data_nx_o   (data_nx),
    .valid_nx_o  (valid_nx)
  );

  // wp_i is taken in the commit cycle only
  pbw_array i_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .wp_i     (wp_i),
    .page_i   (page_nx),
    .data_i   (data_nx),
    .valid_i  (valid_nx),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o)
  );

  pbw_timer #(.CYCLES(WRITE_CYCLES)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (commit),
    .busy_o(busy_o)
  );
endmodule

// File: rtl/pbw_checker.sv
module pbw_checker #(
  parameter int unsigned WRITE_CYCLES = 500000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stop_i,
  input logic       wp_i,
  input logic [6:0] rd_addr_i,
  input logic [7:0] rd_data_o,
  input logic       busy_o
);
  int unsigned run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_len <= 0;
    else if (busy_o) run_len <= run_len + 1;
    else             run_len <= 0;
  end

  assert_busy_after_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));

  assert_busy_length_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_len == WRITE_CYCLES));

  assert_array_only_on_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(stop_i) && $stable(rd_addr_i)) |-> $stable(rd_data_o));

  assert_wp_no_change_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wp_i) && $stable(rd_addr_i)) |-> $stable(rd_data_o));

  assert_busy_ignores_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_o) && $stable(rd_addr_i)) |-> $stable(rd_data_o));
endmodule

bind pbw_page_writer pbw_checker #(.WRITE_CYCLES(WRITE_CYCLES)) i_pbw_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .stop_i   (stop_i),
  .wp_i     (wp_i),
  .rd_addr_i(rd_addr_i),
  .rd_data_o(rd_data_o),
  .busy_o   (busy_o)
);

// File: tb/test_pbw_page_writer.sv
module test_pbw_page_writer;
  localparam int CLK_PERIOD   = 10;
  localparam int WRITE_CYCLES = 20;

  typedef struct packed {
    logic [6:0] addr;
    logic [4:0] n;
    logic [7:0] seed;
    logic       wp;
    logic [3:0] code;
  } row_t;

  localparam int NROWS = 6;
  localparam row_t ROWS [NROWS] = '{
    '{7'h00, 5'd1,  8'h11, 1'b0, 4'd2},  // R2 one-byte write
    '{7'h0d, 5'd5,  8'h20, 1'b0, 4'd2},  // R2 column wraps 15 -> 0
    '{7'h75, 5'd20, 8'h40, 1'b0, 4'd3},  // R3 more than 16 bytes
    '{7'h00, 5'd2,  8'he0, 1'b1, 4'd7},  // R7 protected
    '{7'h7f, 5'd1,  8'ha5, 1'b0, 4'd8},  // R8 last address
    '{7'h02, 5'd1,  8'h55, 1'b0, 4'd4}   // R4 neighbours untouched
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 0, addr_load_i = 0, byte_valid_i = 0, stop_i = 0, wp_i = 0;
  logic [6:0] addr_i = '0, rd_addr_i = '0;
  logic [7:0] byte_i = '0;
  logic [7:0] rd_data_o;
  logic       busy_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] model [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  pbw_page_writer #(.WRITE_CYCLES(WRITE_CYCLES)) i_pbw_page_writer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .addr_load_i(addr_load_i),
    .addr_i(addr_i), .byte_valid_i(byte_valid_i), .byte_i(byte_i), .stop_i(stop_i),
    .wp_i(wp_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .busy_o(busy_o)
  );

  function automatic string tag(input logic [3:0] c);
    case (c)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    rd_addr_i = a;
    #1;
    d = rd_data_o;
  endtask

  task automatic check_loc(input string req, input logic [6:0] a);
    logic [7:0] d;
    rd(a, d);
    check(req, $sformatf("loc %0h", a), d, model[a]);
  endtask

  task automatic pulse_start();
    start_i = 1; @(negedge clk); start_i = 0;
  endtask

  task automatic load_addr(input logic [6:0] a);
    addr_load_i = 1; addr_i = a; @(negedge clk); addr_load_i = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    byte_valid_i = 1; byte_i = b; @(negedge clk); byte_valid_i = 0;
  endtask

  task automatic pulse_stop(input logic wp);
    wp_i = wp; stop_i = 1; @(negedge clk); stop_i = 0; wp_i = 0;
  endtask

  task automatic busy_len(output int cnt);
    cnt = 0;
    while (busy_o && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int cnt;
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1", "busy after reset", busy_o, 0);
    check_loc("R1", 7'h00);
    check_loc("R1", 7'h55);
    check_loc("R1", 7'h7f);

    // table walk
    for (int r = 0; r < NROWS; r++) begin
      logic [7:0] pbuf [16];
      bit         pval [16];
      logic [2:0] pg;
      for (int c = 0; c < 16; c++) pval[c] = 0;
      pg = ROWS[r].addr[6:4];
      pulse_start();
      load_addr(ROWS[r].addr);
      for (int i = 0; i < int'(ROWS[r].n); i++) begin
        logic [3:0] col;
        col = 4'(int'(ROWS[r].addr[3:0]) + i);
        pbuf[col] = ROWS[r].seed + 8'(i);
        pval[col] = 1;
        send_byte(ROWS[r].seed + 8'(i));
      end
      pulse_stop(ROWS[r].wp);
      check("R6", "busy after stop", busy_o, 1);
      busy_len(cnt);
      check("R6", "busy length", cnt, WRITE_CYCLES);
      if (!ROWS[r].wp)
        for (int c = 0; c < 16; c++)
          if (pval[c]) model[{pg, 4'(c)}] = pbuf[c];
      for (int c = 0; c < 16; c++) check_loc(tag(ROWS[r].code), {pg, 4'(c)});
    end

    // R12 read port is combinational
    @(negedge clk);
    rd(7'h7f, d); check("R12", "read 7f", d, 8'ha5);
    rd(7'h02, d); check("R12", "read 02", d, 8'h55);

    // R5 no change before stop, visible right after
    pulse_start(); load_addr(7'h20); send_byte(8'h5a);
    rd(7'h20, d); check("R5", "before stop", d, 8'h00);
    pulse_stop(0);
    rd(7'h20, d); check("R5", "after stop", d, 8'h5a);
    model[7'h20] = 8'h5a;
    busy_len(cnt);

    // R9 repeated start clears buffer
    pulse_start(); load_addr(7'h21); send_byte(8'h77);
    pulse_start(); pulse_stop(0);
    check("R9", "busy after cleared stop", busy_o, 0);
    check_loc("R9", 7'h21);
    // R9 empty stop
    pulse_stop(0);
    check("R9", "busy after empty stop", busy_o, 0);

    // R10 inputs ignored while busy
    pulse_start(); load_addr(7'h50); send_byte(8'h99); pulse_stop(0);
    model[7'h50] = 8'h99;
    cnt = 0;
    for (int k = 0; k < WRITE_CYCLES + 4; k++) begin
      if (busy_o) cnt++;
      start_i      = (k == 2);
      addr_load_i  = (k == 3); addr_i = 7'h51;
      byte_valid_i = (k == 4); byte_i = 8'h33;
      stop_i       = (k == 5);
      @(negedge clk);
    end
    start_i = 0; addr_load_i = 0; byte_valid_i = 0; stop_i = 0;
    check("R10", "busy length with traffic", cnt, WRITE_CYCLES);
    pulse_stop(0);
    check("R10", "no leftover bytes", busy_o, 0);
    check_loc("R10", 7'h51);
    check_loc("R10", 7'h50);

    // R11 byte together with stop
    pulse_start(); load_addr(7'h62); send_byte(8'h10);
    byte_valid_i = 1; byte_i = 8'h11; stop_i = 1;
    @(negedge clk);
    byte_valid_i = 0; stop_i = 0;
    model[7'h62] = 8'h10; model[7'h63] = 8'h11;
    check("R11", "busy", busy_o, 1);
    check_loc("R11", 7'h62);
    check_loc("R11", 7'h63);
    busy_len(cnt);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule